// File: doc/BRIEF.md
# SPI Master/Slave Port with Control Register

This block is a single-byte serial peripheral interface port that works either as the clock-driving master or as a clocked slave. Software sets it up through an 8-bit control register on a small synchronous register port. That register holds the interrupt enable, the port enable, the bit order, the role, the clock polarity, the clock phase and a two-bit master clock rate. A write to the data register in master mode starts an eight-bit exchange. In slave mode the byte written is what the port shifts out the next time an external master selects it.

Each finished byte sets a completion flag. The flag, the interrupt enable and a global interrupt enable input together drive an interrupt request. Software clears the flag by reading the status register while the flag is set and then touching the data register.

In master mode the port watches the select input. If another device pulls select low, the port drops back to slave and sets the completion flag, and software has to select master mode again. In slave mode the incoming clock, data and select are passed through synchronizers into the system clock domain. While select is high the slave releases its serial output and forgets any partly received byte.

Top module: `spi_port`

## Requirements
- R1: Register port: address 0 is the control register with bit 7 irq enable, bit 6 port enable, bit 5 lsb-first, bit 4 master, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate. Address 1 is status, with the completion flag at bit 7 and the other bits 0. Address 2 reads the last received byte and takes writes of the byte to send. All registers are 0 after reset, and reads are combinational on `reg_addr`.
- R2: `irq` is 1 exactly when the completion flag, control bit 7 and `gie` are all 1.
- R3: With the enable bit 0 no transfer starts, the completion flag stays 0, and `sck_oe`, `mosi_oe` and `miso_oe` are 0.
- R4: With lsb-first 1, bit 0 of the byte is the first bit on the serial line. With lsb-first 0, bit 7 goes first. The same order applies to the bits received.
- R5: In master mode a data write starts an exchange of 8 bits on `mosi_o` and `miso_i`. The completion flag is set once the last clock edge has been driven, and address 2 then reads the received byte.
- R6: The serial clock rests at the polarity bit: low for 0, high for 1, before and after every master transfer.
- R7: With phase 0, data is sampled on the leading clock edge and changed on the trailing edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R8: The master clock period is 4, 16, 64 or 128 system clocks for rate 0, 1, 2 or 3.
- R9: In slave mode the rate bits have no effect. The byte is shifted on the synchronized `sck_i`, `mosi_i` is received, `miso_o` carries the byte written, and the flag is set after the eighth sampled bit.
- R10: In slave mode a high `ss_n_i` releases `miso_o` (`miso_oe` 0) and discards a partly received byte, so the next selection starts at bit 0.
- R11: With the port enabled in master mode, a low `ss_n_i` clears the master bit, aborts any transfer and sets the completion flag.
- R12: The completion flag is cleared only by a data register access that follows a status read made while the flag was set. A data access alone leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, carries the read side effects |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The master side is tried with four transfers, each using a different setting of polarity, phase, bit order and rate and a different asymmetric byte. The incoming line is looped back, once straight and once inverted. This separates a wrong sampling edge from a wrong shifting edge, a swapped bit order on the transmit side from one on the receive side, and a rate decode that returns the wrong period. The slave side is driven by a bench master at a fixed slow pace under several phase, polarity and order settings while the rate bits vary, which shows that the rate does not matter there. A partial byte cut off by deselection shows that the bit counter restarts. A select pulled low in master mode, combined with the interrupt enables and the two-step flag clear, covers the fault and interrupt paths.

// File: rtl/spi_pkg.sv
`timescale 1ns/1ps
// Shared types and register addresses for the SPI port.
// Assumes an 8-bit control word whose bit order is decoded by software.
package spi_pkg;

    typedef struct packed {
        logic       irq_en;     // bit 7
        logic       en;         // bit 6
        logic       lsb_first;  // bit 5
        logic       master;     // bit 4
        logic       cpol;       // bit 3
        logic       cpha;       // bit 2
        logic [1:0] rate;       // bits 1:0
    } spi_ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer for a vector of asynchronous inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module spi_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop captures the raw input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[0] <= RST_VAL;
                    else        stage[0] <= d;
                end
            end else begin : g_next
                // Later flops pass the level along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[g] <= RST_VAL;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/spi_clkdiv.sv
`timescale 1ns/1ps
// Half-period tick generator for the master serial clock.
// Assumes run stays high for a whole transfer; the count restarts when it drops.
module spi_clkdiv #(
    parameter int HALF0 = 2,
    parameter int HALF1 = 8,
    parameter int HALF2 = 32,
    parameter int HALF3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);

    localparam int CW = $clog2(HALF3) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Pick the terminal count for the selected rate.
    always_comb begin
        case (rate)
            2'd0:    lim = CW'(HALF0 - 1);
            2'd1:    lim = CW'(HALF1 - 1);
            2'd2:    lim = CW'(HALF2 - 1);
            default: lim = CW'(HALF3 - 1);
        endcase
    end

    // Count system clocks within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (!run || cnt == lim) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == lim);

endmodule

// File: rtl/spi_regs.sv
`timescale 1ns/1ps
// Register file: control, status flag with two-step clear, data buffers, irq.
// Assumes one register access per cycle; a flag set wins over a clear.
module spi_regs
    import spi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          gie,
    output logic          irq,
    input  logic          busy,
    input  logic          done,
    input  logic          fault,
    input  logic [DW-1:0] rx_byte,
    output spi_ctrl_t     ctrl,
    output logic [DW-1:0] txbuf,
    output logic          start,
    output logic          flag
);

    logic          armed;
    logic [DW-1:0] rxbuf;
    logic          data_acc;
    logic          stat_rd;

    assign data_acc = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
    assign stat_rd  = reg_rd && (reg_addr == ADDR_STAT);

    // Control register; a mode fault drops the master bit after any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= spi_ctrl_t'(reg_wdata);
            if (fault) ctrl.master <= 1'b0;
        end
    end

    // Transmit and receive byte buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txbuf <= '0;
            rxbuf <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_DATA) txbuf <= reg_wdata[DW-1:0];
            if (done) rxbuf <= rx_byte;
        end
    end

    // Completion flag and the status-read arm for its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (done || fault)        flag <= 1'b1;
            else if (armed && data_acc) flag <= 1'b0;

            if (stat_rd && flag)      armed <= 1'b1;
            else if (data_acc || !flag) armed <= 1'b0;
        end
    end

    assign start = reg_wr && (reg_addr == ADDR_DATA) && ctrl.en && ctrl.master
                   && !busy && !fault;

    assign irq = flag && ctrl.irq_en && gie;

    // Combinational read mux.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl;
            ADDR_STAT: reg_rdata = {flag, 7'b0};
            ADDR_DATA: reg_rdata = 8'(rxbuf);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_engine.sv
`timescale 1ns/1ps
// Shift engine shared by master and slave roles.
// Master edges come from the divider tick; slave edges come from the
// synchronized serial clock. Assumes slave inputs are already synchronized.
module spi_engine
    import spi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  spi_ctrl_t     ctrl,
    input  logic          start,
    input  logic [DW-1:0] start_byte,
    input  logic [DW-1:0] txbuf,
    input  logic          tick,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic          ss_s,
    input  logic          miso_i,
    output logic          sck_o,
    output logic          sck_oe,
    output logic          mosi_o,
    output logic          mosi_oe,
    output logic          miso_o,
    output logic          miso_oe,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [DW-1:0] rx_byte
);

    localparam int             EW        = $clog2(2 * DW);
    localparam int             NW        = $clog2(DW) + 1;
    localparam logic [EW-1:0]  LAST_EDGE = EW'(2 * DW - 1);
    localparam logic [NW-1:0]  LAST_SAMP = NW'(DW - 1);
    localparam logic [NW-1:0]  FULL_SAMP = NW'(DW);

    logic [DW-1:0] tx_sr;
    logic [DW-1:0] rx_sr;
    logic [EW-1:0] edge_cnt;
    logic [NW-1:0] nsamp;
    logic          sck_t;
    logic          sck_prev;
    logic          slave_act;
    logic          m_ev, m_lead, m_trail;
    logic          s_lead, s_trail;
    logic          ev_lead, ev_trail;
    logic          smp, chg, do_shift;
    logic          in_bit, out_bit;
    logic          slave_last;

    assign fault     = ctrl.en && ctrl.master && !ss_s;
    assign slave_act = ctrl.en && !ctrl.master && !ss_s;

    // Edge events from both clock sources.
    assign m_ev     = busy && tick;
    assign m_lead   = m_ev && !edge_cnt[0];
    assign m_trail  = m_ev &&  edge_cnt[0];
    assign s_lead   = slave_act && (sck_prev == ctrl.cpol) && (sck_s != ctrl.cpol);
    assign s_trail  = slave_act && (sck_prev != ctrl.cpol) && (sck_s == ctrl.cpol);
    assign ev_lead  = m_lead  || s_lead;
    assign ev_trail = m_trail || s_trail;

    // Phase picks which edge samples and which edge shifts.
    assign smp      = ctrl.cpha ? ev_trail : ev_lead;
    assign chg      = ctrl.cpha ? ev_lead  : ev_trail;
    assign do_shift = chg && (nsamp != '0) && (nsamp != FULL_SAMP);

    assign in_bit     = ctrl.master ? miso_i : mosi_s;
    assign out_bit    = ctrl.lsb_first ? tx_sr[0] : tx_sr[DW-1];
    assign slave_last = smp && !ctrl.master && (nsamp == LAST_SAMP);

    // Transfer sequencing, shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            sck_t    <= 1'b0;
            edge_cnt <= '0;
            nsamp    <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
        end else begin
            done <= 1'b0;
            if (!ctrl.en || fault) begin
                busy     <= 1'b0;
                sck_t    <= 1'b0;
                edge_cnt <= '0;
                nsamp    <= '0;
                tx_sr    <= txbuf;
            end else if (start) begin
                busy     <= 1'b1;
                sck_t    <= 1'b0;
                edge_cnt <= '0;
                nsamp    <= '0;
                tx_sr    <= start_byte;
            end else if (!ctrl.master && ss_s) begin
                nsamp    <= '0;
                tx_sr    <= txbuf;
            end else begin
                if (m_ev) begin
                    sck_t    <= !sck_t;
                    edge_cnt <= edge_cnt + 1'b1;
                    if (edge_cnt == LAST_EDGE) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
                if (smp) begin
                    rx_sr <= ctrl.lsb_first ? {in_bit, rx_sr[DW-1:1]}
                                            : {rx_sr[DW-2:0], in_bit};
                    if (slave_last) begin
                        nsamp <= '0;
                        done  <= 1'b1;
                        tx_sr <= txbuf;
                    end else begin
                        nsamp <= nsamp + 1'b1;
                    end
                end else if (do_shift) begin
                    tx_sr <= ctrl.lsb_first ? {1'b0, tx_sr[DW-1:1]}
                                            : {tx_sr[DW-2:0], 1'b0};
                end
            end
        end
    end

    // Previous synchronized slave clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // Registered pin drive enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_oe  <= 1'b0;
            mosi_oe <= 1'b0;
            miso_oe <= 1'b0;
        end else begin
            sck_oe  <= ctrl.en && ctrl.master;
            mosi_oe <= ctrl.en && ctrl.master;
            miso_oe <= slave_act;
        end
    end

    assign sck_o   = ctrl.cpol ^ sck_t;
    assign mosi_o  = out_bit;
    assign miso_o  = out_bit;
    assign rx_byte = rx_sr;

endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
// SPI port top: register file, master clock divider, input synchronizers
// and the shared shift engine. Assumes pads and muxing live outside.
module spi_port
    import spi_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HALF0       = 2,
    parameter int HALF1       = 8,
    parameter int HALF2       = 32,
    parameter int HALF3       = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       gie,
    output logic       irq,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       mosi_i,
    output logic       mosi_o,
    output logic       mosi_oe,
    input  logic       miso_i,
    output logic       miso_o,
    output logic       miso_oe,
    input  logic       ss_n_i
);

    spi_ctrl_t     ctrl_q;
    logic [DW-1:0] txbuf;
    logic [DW-1:0] rx_byte;
    logic          start;
    logic          flag_q;
    logic          busy;
    logic          done_q;
    logic          fault;
    logic          tick;
    logic          ss_s, sck_s, mosi_s;

    spi_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gie       (gie),
        .irq       (irq),
        .busy      (busy),
        .done      (done_q),
        .fault     (fault),
        .rx_byte   (rx_byte),
        .ctrl      (ctrl_q),
        .txbuf     (txbuf),
        .start     (start),
        .flag      (flag_q)
    );

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sck_i, mosi_i}),
        .q     ({ss_s, sck_s, mosi_s})
    );

    spi_clkdiv #(.HALF0(HALF0), .HALF1(HALF1), .HALF2(HALF2), .HALF3(HALF3)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .rate  (ctrl_q.rate),
        .tick  (tick)
    );

    spi_engine #(.DW(DW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl_q),
        .start      (start),
        .start_byte (reg_wdata[DW-1:0]),
        .txbuf      (txbuf),
        .tick       (tick),
        .sck_s      (sck_s),
        .mosi_s     (mosi_s),
        .ss_s       (ss_s),
        .miso_i     (miso_i),
        .sck_o      (sck_o),
        .sck_oe     (sck_oe),
        .mosi_o     (mosi_o),
        .mosi_oe    (mosi_oe),
        .miso_o     (miso_o),
        .miso_oe    (miso_oe),
        .busy       (busy),
        .done       (done_q),
        .fault      (fault),
        .rx_byte    (rx_byte)
    );

endmodule

// File: rtl/spi_port_chk.sv
`timescale 1ns/1ps
// Assertion checker for spi_port, attached through bind.
// Assumes the synchronous active-low reset of the port.
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl_bits,
    input logic       flag,
    input logic       fault,
    input logic       done,
    input logic       gie,
    input logic       irq,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       miso_oe,
    input logic       ss_s,
    input logic [1:0] reg_addr,
    input logic       reg_rd,
    input logic       reg_wr
);

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie); // R2

    AST_OFF_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[6] && !$past(ctrl_bits[6])) |-> (!sck_oe && !mosi_oe && !miso_oe)); // R3

    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sck_o == ctrl_bits[3])); // R6

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && $past(ss_s)) |-> !miso_oe); // R10

    AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !ctrl_bits[4]); // R11

    AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> flag); // R11

    AST_FLAG_CLEAR_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past((reg_rd || reg_wr) && reg_addr == 2'd2)); // R12

endmodule

bind spi_port spi_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_bits (ctrl_q),
    .flag      (flag_q),
    .fault     (fault),
    .done      (done_q),
    .gie       (gie),
    .irq       (irq),
    .sck_o     (sck_o),
    .sck_oe    (sck_oe),
    .mosi_oe   (mosi_oe),
    .miso_oe   (miso_oe),
    .ss_s      (ss_s),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr)
);

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
// Directed bench for spi_port: one task per scenario, each checking itself.
module sim_spi_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] r_addr = '0;
    logic       r_wr = 1'b0;
    logic       r_rd = 1'b0;
    logic [7:0] r_wdata = '0;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0;
    logic       irq;
    logic       b_sck = 1'b0;
    logic       b_mosi = 1'b0;
    logic       b_ss = 1'b1;
    logic       minv = 1'b0;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       miso_i;

    int n_tests = 0;
    int n_fail  = 0;

    assign miso_i = mosi_o ^ minv;

    always #4 clk = ~clk;

    spi_port u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(r_addr), .reg_wr(r_wr), .reg_rd(r_rd),
        .reg_wdata(r_wdata), .reg_rdata(reg_rdata), .gie(gie), .irq(irq),
        .sck_i(b_sck), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(b_mosi), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(b_ss)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        r_addr = a; r_wdata = d; r_wr = 1'b1;
        @(posedge clk); #1;
        r_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        r_addr = a; r_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        r_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        r_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_flag();
        logic [7:0] d;
        bus_read(2'd1, d);
        bus_read(2'd2, d);
    endtask

    function automatic logic [7:0] wire_order(input logic [7:0] v, input logic lsb);
        logic [7:0] w;
        for (int i = 0; i < 8; i++) w[i] = lsb ? v[i] : v[7-i];
        return w;
    endfunction

    function automatic int period_of(input logic [1:0] rate);
        case (rate)
            2'd0: return 4;
            2'd1: return 16;
            2'd2: return 64;
            default: return 128;
        endcase
    endfunction

    // R1: reset values and control readback.
    task automatic t_reset_regs();
        logic [7:0] d;
        peek(2'd0, d); chk("R1", "ctrl after reset", d, 8'h00);
        peek(2'd1, d); chk("R1", "status after reset", d, 8'h00);
        peek(2'd2, d); chk("R1", "data after reset", d, 8'h00);
        chk("R3", "enables after reset", {sck_oe, mosi_oe, miso_oe}, 3'b000);
        chk("R2", "irq after reset", irq, 1'b0);
        bus_write(2'd0, 8'hA5);
        peek(2'd0, d); chk("R1", "ctrl readback", d, 8'hA5);
        bus_write(2'd0, 8'h00);
        peek(2'd0, d); chk("R1", "ctrl cleared", d, 8'h00);
    endtask

    // R3: disabled port ignores a data write in master role.
    task automatic t_disabled();
        logic [7:0] d;
        bus_write(2'd0, 8'h10);
        bus_write(2'd2, 8'h77);
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk("R3", "pins released while off", {sck_oe, mosi_oe, miso_oe}, 3'b000);
        chk("R3", "no clock while off", sck_o, 1'b0);
        peek(2'd1, d); chk("R3", "no flag while off", d, 8'h00);
    endtask

    // R4 R5 R6 R7 R8: one master transfer with loopback.
    task automatic t_master(input logic dord, input logic cpol, input logic cpha,
                            input logic [1:0] rate, input logic [7:0] tx, input logic inv);
        logic [7:0] d;
        logic [7:0] cap;
        logic       prev;
        int         nb, t0, t1, nlead, cyc;
        cap = '0; nb = 0; t0 = 0; t1 = 0; nlead = 0; cyc = 0;
        bus_write(2'd0, {2'b01, dord, 1'b1, cpol, cpha, rate});
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6", "idle level before transfer", sck_o, cpol);
        chk("R5", "master drives pins", {sck_oe, mosi_oe}, 2'b11);
        minv = inv;
        bus_write(2'd2, tx);
        r_addr = 2'd1;
        prev = sck_o;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            cyc++;
            if (sck_o !== prev) begin
                if (sck_o != cpol) begin
                    nlead++;
                    if (nlead == 1) t0 = cyc;
                    if (nlead == 2) t1 = cyc;
                end
                if ((sck_o != cpol) != cpha) begin
                    if (nb < 8) cap[nb] = mosi_o;
                    nb++;
                end
            end
            prev = sck_o;
            if (reg_rdata[7]) break;
        end
        chk("R7", "sample edges seen", nb, 8);
        chk("R4", "bit order on line", cap, wire_order(tx, dord));
        chk("R8", "clock period", t1 - t0, period_of(rate));
        @(negedge clk);
        chk("R6", "idle level after transfer", sck_o, cpol);
        peek(2'd1, d); chk("R5", "flag after 8 bits", d, 8'h80);
        peek(2'd2, d); chk("R5", "received byte", d, tx ^ {8{inv}});
        clear_flag();
        peek(2'd1, d); chk("R12", "flag cleared", d, 8'h00);
        minv = 1'b0;
    endtask

    // R9 R10: slave transfer driven by the bench as master.
    task automatic t_slave(input logic dord, input logic cpol, input logic cpha,
                           input logic [1:0] rate, input logic [7:0] stx,
                           input logic [7:0] mtx, input int nbits);
        localparam int H = 6;
        logic [7:0] d;
        logic [7:0] cap;
        logic       b;
        cap = '0;
        b_ss = 1'b1; b_sck = cpol;
        bus_write(2'd0, {2'b01, dord, 1'b0, cpol, cpha, rate});
        bus_write(2'd2, stx);
        repeat (6) @(posedge clk);
        #1 b_ss = 1'b0;
        repeat (H) @(posedge clk);
        @(negedge clk);
        chk("R10", "slave drives miso when selected", miso_oe, 1'b1);
        for (int i = 0; i < nbits; i++) begin
            b = dord ? mtx[i] : mtx[7-i];
            @(posedge clk); #1;
            if (cpha) b_sck = ~cpol;
            b_mosi = b;
            repeat (H) @(posedge clk);
            @(negedge clk); cap[i] = miso_o;
            @(posedge clk); #1;
            b_sck = cpha ? cpol : ~cpol;
            repeat (H) @(posedge clk);
            if (!cpha) begin
                #1 b_sck = cpol;
                repeat (H) @(posedge clk);
            end
        end
        #1 b_ss = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R10", "miso released on deselect", miso_oe, 1'b0);
        if (nbits == 8) begin
            chk("R9", "slave sent byte", cap, wire_order(stx, dord));
            peek(2'd1, d); chk("R9", "slave flag", d, 8'h80);
            peek(2'd2, d); chk("R9", "slave received byte", d, mtx);
            clear_flag();
        end else begin
            peek(2'd1, d); chk("R10", "no flag for partial byte", d, 8'h00);
        end
    endtask

    // R11 R2 R12: mode fault, interrupt gating and the two-step flag clear.
    task automatic t_fault_irq();
        logic [7:0] d;
        gie = 1'b0;
        bus_write(2'd0, 8'hD0);
        repeat (3) @(posedge clk);
        #1 b_ss = 1'b0;
        repeat (6) @(posedge clk);
        peek(2'd0, d); chk("R11", "master bit dropped", d[4], 1'b0);
        peek(2'd1, d); chk("R11", "fault sets flag", d, 8'h80);
        chk("R2", "irq blocked by gie", irq, 1'b0);
        @(posedge clk); #1 b_ss = 1'b1;
        gie = 1'b1;
        @(negedge clk);
        chk("R2", "irq with all enables", irq, 1'b1);
        bus_write(2'd0, 8'h40);
        @(negedge clk);
        chk("R2", "irq blocked by enable bit", irq, 1'b0);
        bus_write(2'd0, 8'hC0);
        @(negedge clk);
        chk("R2", "irq back on", irq, 1'b1);
        bus_read(2'd2, d);
        peek(2'd1, d); chk("R12", "data read alone keeps flag", d, 8'h80);
        clear_flag();
        peek(2'd1, d); chk("R12", "status then data clears flag", d, 8'h00);
        chk("R2", "irq drops with flag", irq, 1'b0);
        gie = 1'b0;
        bus_write(2'd0, 8'hD0);
        peek(2'd0, d); chk("R11", "master reselected by software", d[4], 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_reset_regs();
        t_disabled();
        t_master(1'b0, 1'b0, 1'b0, 2'd0, 8'hB4, 1'b0);
        t_master(1'b1, 1'b1, 1'b1, 2'd1, 8'h3C, 1'b1);
        t_master(1'b1, 1'b0, 1'b1, 2'd2, 8'h81, 1'b0);
        t_master(1'b0, 1'b1, 1'b0, 2'd3, 8'h5A, 1'b1);
        t_slave(1'b0, 1'b0, 1'b0, 2'd3, 8'h6D, 8'hC2, 8);
        t_slave(1'b1, 1'b1, 1'b1, 2'd0, 8'h19, 8'hE7, 8);
        t_slave(1'b0, 1'b1, 1'b0, 2'd2, 8'hA3, 8'h4B, 3);
        t_slave(1'b0, 1'b1, 1'b0, 2'd2, 8'hA3, 8'h4B, 8);
        t_slave(1'b1, 1'b0, 1'b1, 2'd1, 8'hF0, 8'h0E, 8);
        t_fault_irq();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule